// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is a serial slave on a two-wire bus (clock line and data line, open drain) that gives a host read and write access to a bank of 8-bit configuration registers. Seven input pins set the device's bus address. Both bus lines are oversampled on the system clock, synchronised and deglitched, and the protocol engine runs only on the filtered copies. The block pulls the data line low through a single output-enable signal. The pad itself sits outside the block.

A write transaction has a fixed layout. The first data byte after the address loads the register pointer. Each later byte is written at the pointer, and the pointer then advances. A read transaction returns bytes from the pointer, which advances after each byte. A repeated START lets the host set the pointer in a write and then read from it without releasing the bus. On the register side the block has a one-cycle write strobe with its address and data. It has a combinational read port that is addressed by the pointer. It also has a one-cycle clear-on-read strobe, which marks each byte that has been fully shifted out.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After a START, the block takes the first 8 bits MSB first as a 7-bit address followed by a direction bit (1 = read, 0 = write). It pulls SDA low in the ninth clock only when the 7 bits equal `dev_addr_i`.
- R2: When the address does not match, the block leaves SDA released and produces no register strobe until the next START.
- R3: Before the first START, and after a STOP or a failed address match, the block ignores all clock and data activity and does not drive SDA.
- R4: In a write, the first data byte loads the pointer. Each later byte produces a one-cycle `reg_wr_o` carrying the pointer and the byte. The pointer then increments modulo 2^PTR_W, so 0xFF wraps to 0x00.
- R5: The block acknowledges every data byte of an addressed write by pulling SDA low in the ninth clock.
- R6: In a read, each byte is `reg_rdata_i` at `reg_raddr_o` (the pointer), sent MSB first, and the pointer then increments. A repeated START that switches from write to read keeps the pointer.
- R7: The block changes `sda_oe_o` only while SCL is low, that is, after a falling edge.
- R8: At the eighth falling SCL edge of every transmitted byte, `reg_rclr_o` pulses for one cycle with `reg_rclr_addr_o` set to the address of that byte.
- R9: A NACK from the host (SDA high in the ninth clock) after a read byte stops the block from driving SDA until the next START.
- R10: A pulse on SCL or SDA shorter than FILT_LEN system-clock cycles has no effect on the protocol.
- R11: A STOP at any point returns the block to idle and discards a partly received byte without a write strobe.
- R12: While reset is asserted, and right after it, `sda_oe_o`, `reg_wr_o` and `reg_rclr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_addr_i | input | 7 | Device address on the bus |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | PTR_W | Write address |
| reg_wdata_o | output | 8 | Write data |
| reg_raddr_o | output | PTR_W | Read fetch address (current pointer) |
| reg_rdata_i | input | 8 | Register contents at `reg_raddr_o` |
| reg_rclr_o | output | 1 | One-cycle clear-on-read strobe |
| reg_rclr_addr_o | output | PTR_W | Address of the byte just read |

## Verification
The bench uses the default parameters: two synchroniser stages, a three-sample filter window and an 8-bit pointer. With these values a two-cycle glitch on either line is shorter than the filter window and must vanish. The full 8-bit pointer also allows the wrap from 0xFF to 0x00 to be checked. Each bus quarter-bit lasts 20 system clocks, well above the roughly six cycles of filter latency. This leaves the slave's data changes clearly inside the SCL-low phase.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
   localparam int BYTE_BITS = 8;
   localparam int ADDR_BITS = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK
   } slv_state_e;
endpackage

// File: rtl/cfg_i2c_line_filter.sv
module cfg_i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end
   assign samp = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_o <= 1'b1;
            else        line_o <= samp;
         end
      end else begin : g_window
         logic [FILT_LEN-1:0] win_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q  <= '1;
               line_o <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], samp};
               if (&win_q)       line_o <= 1'b1;
               else if (~|win_q) line_o <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_i2c_bus_events.sv
module cfg_i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_evt,
   output logic stop_evt,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/cfg_i2c_slave_ctrl.sv
module cfg_i2c_slave_ctrl
   import cfg_i2c_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sda_f,
   input  logic                 start_evt,
   input  logic                 stop_evt,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic [ADDR_BITS-1:0] dev_addr_i,
   output logic                 sda_oe_o,
   output logic                 reg_wr_o,
   output logic [PTR_W-1:0]     reg_waddr_o,
   output logic [BYTE_BITS-1:0] reg_wdata_o,
   output logic [PTR_W-1:0]     reg_raddr_o,
   input  logic [BYTE_BITS-1:0] reg_rdata_i,
   output logic                 reg_rclr_o,
   output logic [PTR_W-1:0]     reg_rclr_addr_o
);
   localparam int CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

   slv_state_e           state_q;
   logic [CNT_W-1:0]     bit_cnt_q;
   logic [BYTE_BITS-1:0] rx_q, tx_q;
   logic [PTR_W-1:0]     ptr_q;
   logic                 first_q, rw_q, nack_q;
   logic                 byte_done;

   assign byte_done   = (bit_cnt_q == FULL);
   assign reg_raddr_o = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q         <= ST_IDLE;
         bit_cnt_q       <= '0;
         rx_q            <= '0;
         tx_q            <= '0;
         ptr_q           <= '0;
         first_q         <= 1'b0;
         rw_q            <= 1'b0;
         nack_q          <= 1'b0;
         sda_oe_o        <= 1'b0;
         reg_wr_o        <= 1'b0;
         reg_waddr_o     <= '0;
         reg_wdata_o     <= '0;
         reg_rclr_o      <= 1'b0;
         reg_rclr_addr_o <= '0;
      end else begin
         reg_wr_o   <= 1'b0;
         reg_rclr_o <= 1'b0;
         if (start_evt) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
            sda_oe_o  <= 1'b0;
            first_q   <= 1'b1;
         end else if (stop_evt) begin
            state_q  <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: ;
               ST_ADDR, ST_WR_BYTE: begin
                  if (scl_rise && !byte_done) begin
                     rx_q      <= {rx_q[BYTE_BITS-2:0], sda_f};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
                  if (scl_fall && byte_done) begin
                     if (state_q == ST_ADDR) begin
                        if (rx_q[BYTE_BITS-1:1] == dev_addr_i) begin
                           rw_q     <= rx_q[0];
                           sda_oe_o <= 1'b1;
                           state_q  <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        sda_oe_o <= 1'b1;
                        state_q  <= ST_WR_ACK;
                        if (first_q) begin
                           ptr_q   <= rx_q[PTR_W-1:0];
                           first_q <= 1'b0;
                        end else begin
                           reg_wr_o    <= 1'b1;
                           reg_waddr_o <= ptr_q;
                           reg_wdata_o <= rx_q;
                           ptr_q       <= ptr_q + 1'b1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK, ST_WR_ACK: begin
                  if (scl_fall) begin
                     bit_cnt_q <= '0;
                     if (state_q == ST_ADDR_ACK && rw_q) begin
                        tx_q     <= reg_rdata_i;
                        sda_oe_o <= ~reg_rdata_i[BYTE_BITS-1];
                        state_q  <= ST_RD_BYTE;
                     end else begin
                        sda_oe_o <= 1'b0;
                        state_q  <= ST_WR_BYTE;
                     end
                  end
               end
               ST_RD_BYTE: begin
                  if (scl_rise && !byte_done) bit_cnt_q <= bit_cnt_q + 1'b1;
                  if (scl_fall) begin
                     if (byte_done) begin
                        sda_oe_o        <= 1'b0;
                        reg_rclr_o      <= 1'b1;
                        reg_rclr_addr_o <= ptr_q;
                        ptr_q           <= ptr_q + 1'b1;
                        state_q         <= ST_RD_ACK;
                     end else begin
                        tx_q     <= {tx_q[BYTE_BITS-2:0], 1'b0};
                        sda_oe_o <= ~tx_q[BYTE_BITS-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) nack_q <= sda_f;
                  if (scl_fall) begin
                     if (nack_q) begin
                        state_q <= ST_IDLE;
                     end else begin
                        bit_cnt_q <= '0;
                        tx_q      <= reg_rdata_i;
                        sda_oe_o  <= ~reg_rdata_i[BYTE_BITS-1];
                        state_q   <= ST_RD_BYTE;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int PTR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic [6:0]       dev_addr_i,
   output logic             reg_wr_o,
   output logic [PTR_W-1:0] reg_waddr_o,
   output logic [7:0]       reg_wdata_o,
   output logic [PTR_W-1:0] reg_raddr_o,
   input  logic [7:0]       reg_rdata_i,
   output logic             reg_rclr_o,
   output logic [PTR_W-1:0] reg_rclr_addr_o
);
   localparam int NUM_LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
         $error("PTR_W must lie in 1..8");
      end
   endgenerate

   logic [NUM_LINES-1:0] raw_lines, filt_lines;
   logic start_evt, stop_evt, scl_rise, scl_fall;

   assign raw_lines = {sda_i, scl_i};

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_filt
      cfg_i2c_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[i]),
         .line_o(filt_lines[i])
      );
   end

   cfg_i2c_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (filt_lines[0]),
      .sda_f    (filt_lines[1]),
      .start_evt(start_evt),
      .stop_evt (stop_evt),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall)
   );

   cfg_i2c_slave_ctrl #(.PTR_W(PTR_W)) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .sda_f          (filt_lines[1]),
      .start_evt      (start_evt),
      .stop_evt       (stop_evt),
      .scl_rise       (scl_rise),
      .scl_fall       (scl_fall),
      .dev_addr_i     (dev_addr_i),
      .sda_oe_o       (sda_oe_o),
      .reg_wr_o       (reg_wr_o),
      .reg_waddr_o    (reg_waddr_o),
      .reg_wdata_o    (reg_wdata_o),
      .reg_raddr_o    (reg_raddr_o),
      .reg_rdata_i    (reg_rdata_i),
      .reg_rclr_o     (reg_rclr_o),
      .reg_rclr_addr_o(reg_rclr_addr_o)
   );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_oe_o,
   input logic             reg_wr_o,
   input logic             reg_rclr_o,
   input logic [PTR_W-1:0] reg_raddr_o,
   input logic [PTR_W-1:0] reg_rclr_addr_o
);
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o); // R4

   AST_RCLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rclr_o |=> !reg_rclr_o); // R8

   AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i); // R7

   AST_PTR_PAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rclr_o |-> reg_raddr_o == reg_rclr_addr_o + 1'b1); // R6

   AST_QUIET_AT_RESET: assert property (@(posedge clk)
      !rst_n |=> !sda_oe_o && !reg_wr_o && !reg_rclr_o); // R12
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.PTR_W(PTR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .scl_i          (scl_i),
   .sda_oe_o       (sda_oe_o),
   .reg_wr_o       (reg_wr_o),
   .reg_rclr_o     (reg_rclr_o),
   .reg_raddr_o    (reg_raddr_o),
   .reg_rclr_addr_o(reg_rclr_addr_o)
);

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
module cfg_i2c_slave_bench;
   localparam int Q = 20;
   localparam logic [6:0] MY_ADDR = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe;
   logic       reg_wr, reg_rclr;
   logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata, reg_rclr_addr;
   logic [7:0] mem [256];
   int         n_chk = 0, n_fail = 0;
   int         wr_cnt = 0, rclr_cnt = 0, oe_rises = 0;
   logic [7:0] last_waddr = '0, last_rclr = '0;
   logic       oe_prev = 1'b0;
   logic       done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_raddr];

   cfg_i2c_slave u_cfg_i2c_slave (
      .clk            (clk),
      .rst_n          (rst_n),
      .scl_i          (scl_m),
      .sda_i          (sda_line),
      .sda_oe_o       (sda_oe),
      .dev_addr_i     (MY_ADDR),
      .reg_wr_o       (reg_wr),
      .reg_waddr_o    (reg_waddr),
      .reg_wdata_o    (reg_wdata),
      .reg_raddr_o    (reg_raddr),
      .reg_rdata_i    (reg_rdata),
      .reg_rclr_o     (reg_rclr),
      .reg_rclr_addr_o(reg_rclr_addr)
   );

   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

   always @(posedge clk) begin
      if (reg_wr) begin
         mem[reg_waddr] <= reg_wdata;
         wr_cnt         <= wr_cnt + 1;
         last_waddr     <= reg_waddr;
      end
      if (reg_rclr) begin
         rclr_cnt  <= rclr_cnt + 1;
         last_rclr <= reg_rclr_addr;
      end
      if (sda_oe && !oe_prev) oe_rises <= oe_rises + 1;
      oe_prev <= sda_oe;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b1; wait_clk(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2 * Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      b = sda_line; wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic get_byte(input logic last, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) get_bit(v[i]);
      put_bit(last);
   endtask

   task automatic t_reset;
      check("R12 sda_oe in reset", sda_oe, 0);
      check("R12 strobes in reset", {reg_wr, reg_rclr}, 0);
   endtask

   task automatic t_ignore_before_start;
      int o = oe_rises;
      for (int i = 6; i >= 0; i--) put_bit(MY_ADDR[i]);
      put_bit(1'b0);
      put_bit(1'b1);
      check("R3 no drive before START", oe_rises - o, 0);
   endtask

   task automatic t_mismatch;
      logic ack;
      int o = oe_rises, w = wr_cnt;
      bus_start();
      put_byte({7'h21, 1'b0}, ack);
      check("R2 no ack on other address", ack, 0);
      put_byte(8'h40, ack);
      put_byte(8'h99, ack);
      check("R2 no drive after mismatch", oe_rises - o, 0);
      check("R2 no write after mismatch", wr_cnt - w, 0);
      bus_stop();
   endtask

   task automatic t_write_burst;
      logic ack;
      int w = wr_cnt;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      check("R1 ack own address", ack, 1);
      put_byte(8'h10, ack);
      check("R5 ack pointer byte", ack, 1);
      put_byte(8'hA1, ack);
      check("R5 ack data byte", ack, 1);
      put_byte(8'hB2, ack);
      put_byte(8'hC3, ack);
      bus_stop();
      check("R4 write count", wr_cnt - w, 3);
      check("R4 last write address", last_waddr, 8'h12);
      check("R4 mem[10]", mem[8'h10], 8'hA1);
      check("R4 mem[11]", mem[8'h11], 8'hB2);
      check("R4 mem[12]", mem[8'h12], 8'hC3);
   endtask

   task automatic t_read_burst;
      logic ack;
      logic [7:0] v;
      int r = rclr_cnt;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h10, ack);
      bus_start();
      put_byte({MY_ADDR, 1'b1}, ack);
      check("R1 ack read address", ack, 1);
      get_byte(1'b0, v);
      check("R6 read byte 0", v, 8'hA1);
      get_byte(1'b0, v);
      check("R6 read byte 1", v, 8'hB2);
      get_byte(1'b1, v);
      check("R6 read byte 2", v, 8'hC3);
      check("R8 clear strobes", rclr_cnt - r, 3);
      check("R8 last clear address", last_rclr, 8'h12);
      begin : nack_tail
         int o = oe_rises;
         for (int i = 0; i < 9; i++) get_bit(v[0]);
         check("R9 no drive after NACK", oe_rises - o, 0);
      end
      bus_stop();
   endtask

   task automatic t_wrap;
      logic ack;
      logic [7:0] v;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'hFF, ack);
      put_byte(8'h11, ack);
      put_byte(8'h22, ack);
      bus_stop();
      check("R4 wrap mem[FF]", mem[8'hFF], 8'h11);
      check("R4 wrap mem[00]", mem[8'h00], 8'h22);
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h00, ack);
      bus_start();
      put_byte({MY_ADDR, 1'b1}, ack);
      get_byte(1'b1, v);
      bus_stop();
      check("R6 read after wrap", v, 8'h22);
   endtask

   task automatic t_glitch;
      logic ack;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h20, ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 8'h3C >> i; wait_clk(Q / 2);
         if (i == 5) begin
            scl_m = 1'b1; wait_clk(2); scl_m = 1'b0;
         end
         wait_clk(Q / 2);
         scl_m = 1'b1; wait_clk(Q);
         if (i == 3) begin
            sda_m = 1'b0; wait_clk(2); sda_m = 1'b1;
         end
         wait_clk(Q);
         scl_m = 1'b0; wait_clk(Q);
      end
      get_bit(ack);
      check("R10 ack despite glitches", ack, 0);
      bus_stop();
      check("R10 data intact", mem[8'h20], 8'h3C);
   endtask

   task automatic t_stop_mid_byte;
      logic ack;
      logic [7:0] v;
      int w = wr_cnt;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h30, ack);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_stop();
      check("R11 no write from partial byte", wr_cnt - w, 0);
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h30, ack);
      bus_start();
      put_byte({MY_ADDR, 1'b1}, ack);
      get_byte(1'b1, v);
      bus_stop();
      check("R11 register unchanged", v, 8'h30 ^ 8'h5A);
   endtask

   initial begin
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(10);
      t_ignore_before_start();
      bus_stop();
      t_mismatch();
      t_write_burst();
      t_read_burst();
      t_wrap();
      t_glitch();
      t_stop_mid_byte();
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule